// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs one access at a time on an external parallel bus on behalf of a processor core. The core raises a request with a space code (program, data or I/O), a write flag and a software wait count. The controller then drives the matching active-low space select, the memory or I/O strobe and the read/write line for the whole access. An access is one address cycle followed by the programmed number of software wait cycles. When two or more software waits are programmed, it is then stretched for as long as the external READY input reads low.

The controller also drives a microstate-complete output, `msc_n`. It is low through all but the last software wait. When `msc_n` is wired back to `ready`, the access gains exactly one external wait and no external logic is needed. When the access ends, the bus pins return to idle and `done` pulses for one clock. A new request is taken in that cycle or in any later idle cycle.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: During and after reset, with no access running, all select and strobe outputs, `rw_n` and `msc_n` are high and `done` is low.
- R2: A request is taken in an idle cycle when `req_space` is 00 (program, `ps_n`), 01 (data, `ds_n`) or 10 (I/O, `is_n`). From the next cycle to the end of the access, only that space's select is low. Code 11 starts no access and gives no `done`.
- R3: `mstrb_n` is low through every cycle of a program or data access and never during an I/O access. `iostrb_n` is low through every cycle of an I/O access only.
- R4: `rw_n` is low through every cycle of a write access and stays high during reads and while idle.
- R5: With a wait count N of 0 or 1, an access lasts exactly N+1 cycles and READY has no effect on it.
- R6: With N of 2 or more, READY is captured by an input register every clock. The access ends at the first edge, from the one closing wait N onward, at which the captured value is high. If READY first reads high in access cycle r (the address cycle is cycle 0) and stays high, the access lasts max(N, r+1)+1 cycles.
- R7: `msc_n` is low in access cycles 1 through N-1, and high in the address cycle, in the last software wait and in any external wait. It stays high throughout when N is 0 or 1.
- R8: With `ready` driven from `msc_n` and N of 2 or more, an access lasts exactly N+2 cycles, which is one external wait.
- R9: `done` is high for exactly one cycle, the first idle cycle after an access, and a request present in that cycle is taken.
- R10: A request raised during a running access is ignored. The space, write flag and wait count are captured when the request is taken, and later changes to those inputs do not alter the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request from the core |
| req_space | input | 2 | Space code: 00 program, 01 data, 10 I/O, 11 reserved |
| req_wr | input | 1 | 1 for a write access |
| wait_cnt | input | WAIT_W | Software wait count for the access |
| ready | input | 1 | External ready, high when the device can finish |
| ps_n | output | 1 | Program space select, active low |
| ds_n | output | 1 | Data space select, active low |
| is_n | output | 1 | I/O space select, active low |
| mstrb_n | output | 1 | Memory strobe, active low |
| iostrb_n | output | 1 | I/O strobe, active low |
| rw_n | output | 1 | High for read, low during a write |
| msc_n | output | 1 | Microstate complete, active low |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong wait counter shows in the same access: the select stays low for the wrong number of cycles, and `msc_n` rises in the wrong cycle. A wrong sequencer state shows as an access that ends too early or hangs, as a `done` pulse with no preceding access, or as a select that changes partway through an access. A fault in the ready path shows only for counts of two or more, as a wrong length in the loopback case or when READY is released late. A wrong decode of the captured space shows in the first active cycle as the wrong select or strobe.

// File: rtl/xbus_wait_pkg.sv
package xbus_wait_pkg;

   localparam int NUM_SPACES = 3;
   localparam int SPACE_W    = 2;

   localparam logic [SPACE_W-1:0] SP_PROG = 2'b00;
   localparam logic [SPACE_W-1:0] SP_DATA = 2'b01;
   localparam logic [SPACE_W-1:0] SP_IO   = 2'b10;
   localparam logic [SPACE_W-1:0] SP_RSVD = 2'b11;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_SOFT = 2'd2,
      PH_EXT  = 2'd3
   } phase_e;

   typedef struct packed {
      logic [SPACE_W-1:0] space;
      logic               wr;
   } acc_t;

endpackage

// File: rtl/xbus_wait_counter.sv
module xbus_wait_counter #(
   parameter int WAIT_W    = 3,
   parameter int READY_MIN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] wait_in,
   input  logic              in_addr,
   input  logic              in_soft,
   output logic              zero,
   output logic              soft_last,
   output logic              ext_ok,
   output logic              msc_window
);

   localparam logic [WAIT_W-1:0] MIN_V = WAIT_W'(READY_MIN);

   logic [WAIT_W-1:0] n_q;
   logic [WAIT_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q   <= '0;
         idx_q <= '0;
      end else if (load) begin
         n_q   <= wait_in;
         idx_q <= '0;
      end else if (in_addr || (in_soft && !soft_last)) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   assign zero       = (n_q == '0);
   assign soft_last  = (idx_q == n_q);
   assign ext_ok     = (n_q >= MIN_V);
   assign msc_window = in_soft && (idx_q < n_q);

endmodule

// File: rtl/xbus_wait_seq.sv
module xbus_wait_seq
   import xbus_wait_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [SPACE_W-1:0] req_space,
   input  logic               req_wr,
   input  logic               ready,
   input  logic               zero,
   input  logic               soft_last,
   input  logic               ext_ok,
   output phase_e             phase,
   output logic               load,
   output acc_t               acc,
   output logic               done
);

   phase_e phase_nxt;
   logic   finish;
   logic   ready_q;
   logic   accept;

   assign accept = (phase == PH_IDLE) && req && (req_space != SP_RSVD);
   assign load   = accept;

   always_comb begin
      phase_nxt = phase;
      finish    = 1'b0;
      unique case (phase)
         PH_IDLE: if (accept) phase_nxt = PH_ADDR;
         PH_ADDR: begin
            if (zero) begin
               phase_nxt = PH_IDLE;
               finish    = 1'b1;
            end else begin
               phase_nxt = PH_SOFT;
            end
         end
         PH_SOFT: begin
            if (soft_last) begin
               if (ext_ok && !ready_q) begin
                  phase_nxt = PH_EXT;
               end else begin
                  phase_nxt = PH_IDLE;
                  finish    = 1'b1;
               end
            end
         end
         PH_EXT: begin
            if (ready_q) begin
               phase_nxt = PH_IDLE;
               finish    = 1'b1;
            end
         end
         default: phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         done    <= 1'b0;
         ready_q <= 1'b1;
         acc     <= '{space: SP_PROG, wr: 1'b0};
      end else begin
         phase   <= phase_nxt;
         done    <= finish;
         ready_q <= ready;
         if (accept) acc <= '{space: req_space, wr: req_wr};
      end
   end

endmodule

// File: rtl/xbus_wait_pins.sv
module xbus_wait_pins
   import xbus_wait_pkg::*;
(
   input  phase_e                phase,
   input  acc_t                  acc,
   input  logic                  msc_window,
   output logic [NUM_SPACES-1:0] sel_n,
   output logic                  mstrb_n,
   output logic                  iostrb_n,
   output logic                  rw_n,
   output logic                  msc_n
);

   logic active;
   assign active = (phase != PH_IDLE);

   for (genvar s = 0; s < NUM_SPACES; s++) begin : g_sel
      assign sel_n[s] = !(active && (acc.space == SPACE_W'(s)));
   end

   assign mstrb_n  = !(active && (acc.space != SP_IO));
   assign iostrb_n = !(active && (acc.space == SP_IO));
   assign rw_n     = !(active && acc.wr);
   assign msc_n    = !msc_window;

endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
   import xbus_wait_pkg::*;
#(
   parameter int WAIT_W    = 3,
   parameter int READY_MIN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [1:0]        req_space,
   input  logic              req_wr,
   input  logic [WAIT_W-1:0] wait_cnt,
   input  logic              ready,
   output logic              ps_n,
   output logic              ds_n,
   output logic              is_n,
   output logic              mstrb_n,
   output logic              iostrb_n,
   output logic              rw_n,
   output logic              msc_n,
   output logic              done
);

   localparam int MAX_WAIT = (1 << WAIT_W) - 1;

   if (WAIT_W < 2) begin : g_bad_width
      $error("xbus_wait_ctrl: WAIT_W must be at least 2");
   end
   if (READY_MIN < 1 || READY_MIN > MAX_WAIT) begin : g_bad_min
      $error("xbus_wait_ctrl: READY_MIN outside the wait count range");
   end

   phase_e                phase;
   acc_t                  acc;
   logic                  load;
   logic                  zero;
   logic                  soft_last;
   logic                  ext_ok;
   logic                  msc_window;
   logic [NUM_SPACES-1:0] sel_n;

   xbus_wait_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_space (req_space),
      .req_wr    (req_wr),
      .ready     (ready),
      .zero      (zero),
      .soft_last (soft_last),
      .ext_ok    (ext_ok),
      .phase     (phase),
      .load      (load),
      .acc       (acc),
      .done      (done)
   );

   xbus_wait_counter #(
      .WAIT_W    (WAIT_W),
      .READY_MIN (READY_MIN)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .wait_in    (wait_cnt),
      .in_addr    (phase == PH_ADDR),
      .in_soft    (phase == PH_SOFT),
      .zero       (zero),
      .soft_last  (soft_last),
      .ext_ok     (ext_ok),
      .msc_window (msc_window)
   );

   xbus_wait_pins u_pins (
      .phase      (phase),
      .acc        (acc),
      .msc_window (msc_window),
      .sel_n      (sel_n),
      .mstrb_n    (mstrb_n),
      .iostrb_n   (iostrb_n),
      .rw_n       (rw_n),
      .msc_n      (msc_n)
   );

   assign ps_n = sel_n[int'(SP_PROG)];
   assign ds_n = sel_n[int'(SP_DATA)];
   assign is_n = sel_n[int'(SP_IO)];

endmodule

// File: rtl/xbus_wait_chk.sv
module xbus_wait_chk (
   input logic clk,
   input logic rst_n,
   input logic ps_n,
   input logic ds_n,
   input logic is_n,
   input logic mstrb_n,
   input logic iostrb_n,
   input logic rw_n,
   input logic msc_n,
   input logic done
);

   logic act;
   assign act = !(ps_n && ds_n && is_n);

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |-> (ps_n && ds_n && is_n && mstrb_n && iostrb_n && rw_n && msc_n && !done));

   assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~{ps_n, ds_n, is_n}));

   assert_mem_strobe_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mstrb_n |-> (is_n && !(ps_n && ds_n)));

   assert_io_strobe_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !iostrb_n |-> !is_n);

   assert_write_in_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rw_n |-> act);

   assert_msc_in_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !msc_n |-> act);

   assert_msc_not_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !$past(act)) |-> msc_n);

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!act && $past(act)));

   assert_select_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (act && $past(act)) |-> $stable({ps_n, ds_n, is_n, rw_n}));

endmodule

bind xbus_wait_ctrl xbus_wait_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ps_n     (ps_n),
   .ds_n     (ds_n),
   .is_n     (is_n),
   .mstrb_n  (mstrb_n),
   .iostrb_n (iostrb_n),
   .rw_n     (rw_n),
   .msc_n    (msc_n),
   .done     (done)
);

// File: tb/tb_xbus_wait_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_wait_ctrl;

   localparam int W = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         req = 1'b0;
   logic [1:0]   req_space = 2'b00;
   logic         req_wr = 1'b0;
   logic [W-1:0] wait_cnt = '0;
   logic         ready;
   logic         ready_drv = 1'b1;
   logic         loop_en = 1'b0;
   logic         ps_n, ds_n, is_n, mstrb_n, iostrb_n, rw_n, msc_n, done;

   assign ready = loop_en ? msc_n : ready_drv;

   xbus_wait_ctrl #(.WAIT_W(W), .READY_MIN(2)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_space(req_space), .req_wr(req_wr),
      .wait_cnt(wait_cnt), .ready(ready), .ps_n(ps_n), .ds_n(ds_n), .is_n(is_n),
      .mstrb_n(mstrb_n), .iostrb_n(iostrb_n), .rw_n(rw_n), .msc_n(msc_n), .done(done)
   );

   typedef struct {
      int    space;
      bit    wr;
      int    n;
      int    len;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails = 0;
   int   idx = 0;
   bit   mon_on = 1'b0;
   bit   ended = 1'b0;

   task automatic chk(bit ok, string what, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   // Monitor: compares each bus cycle against the front of the scoreboard.
   always @(negedge clk) begin
      if (mon_on) begin
         if (!(ps_n && ds_n && is_n)) begin
            if (q.size() == 0) begin
               chk(1'b0, "R2 access with nothing requested", 1, 0);
            end else begin
               chk(ps_n == (q[0].space != 0), {q[0].tag, " R2 program select"}, ps_n, q[0].space != 0);
               chk(ds_n == (q[0].space != 1), {q[0].tag, " R2 data select"}, ds_n, q[0].space != 1);
               chk(is_n == (q[0].space != 2), {q[0].tag, " R2 io select"}, is_n, q[0].space != 2);
               chk(mstrb_n == (q[0].space == 2), {q[0].tag, " R3 memory strobe"}, mstrb_n, q[0].space == 2);
               chk(iostrb_n == (q[0].space != 2), {q[0].tag, " R3 io strobe"}, iostrb_n, q[0].space != 2);
               chk(rw_n == !q[0].wr, {q[0].tag, " R4 rw"}, rw_n, !q[0].wr);
               chk(msc_n == !(idx >= 1 && idx <= q[0].n - 1), {q[0].tag, " R7 msc"},
                   msc_n, !(idx >= 1 && idx <= q[0].n - 1));
               chk(done == 1'b0, {q[0].tag, " R9 done during access"}, done, 0);
            end
            idx++;
         end else begin
            chk({mstrb_n, iostrb_n, rw_n, msc_n} == 4'hF, "R1 idle outputs",
                {mstrb_n, iostrb_n, rw_n, msc_n}, 15);
            if (done) begin
               if (q.size() == 0) begin
                  chk(1'b0, "R9 done without access", 1, 0);
               end else begin
                  chk(idx == q[0].len, {q[0].tag, " access length"}, idx, q[0].len);
                  void'(q.pop_front());
               end
            end else if (idx != 0) begin
               chk(1'b0, "R9 access ended without done", 0, 1);
            end
            idx = 0;
         end
      end
   end

   // Driver: called at a falling edge; returns at the falling edge where done is seen.
   task automatic access(int sp, bit wr, int n, int r, bit loop, bit poke, string tag);
      exp_t e;
      int   len;
      int   i;
      if (n < 2)       len = n + 1;
      else if (loop)   len = n + 2;
      else             len = ((n > r + 1) ? n : r + 1) + 1;
      e.space = sp; e.wr = wr; e.n = n; e.len = len; e.tag = tag;
      q.push_back(e);
      loop_en   = loop;
      req       = 1'b1;
      req_space = 2'(sp);
      req_wr    = wr;
      wait_cnt  = W'(n);
      @(negedge clk);
      req      = 1'b0;
      wait_cnt = W'(~n);
      req_wr   = ~wr;
      i = 0;
      forever begin
         ready_drv = (i >= r);
         @(negedge clk);
         i++;
         if (done) break;
         if (i > 100) begin
            chk(1'b0, {tag, " access never finished"}, i, len);
            break;
         end
         if (poke && i == 1) begin
            req       = 1'b1;
            req_space = 2'b10;
         end else begin
            req = 1'b0;
         end
      end
      req       = 1'b0;
      ready_drv = 1'b1;
      loop_en   = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs held idle during reset
      chk({ps_n, ds_n, is_n, mstrb_n, iostrb_n, rw_n, msc_n} == 7'h7F, "R1 reset outputs",
          {ps_n, ds_n, is_n, mstrb_n, iostrb_n, rw_n, msc_n}, 127);
      chk(done == 1'b0, "R1 reset done", done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
      @(negedge clk);

      // R5: zero and one wait, back to back (R9 accept in the done cycle)
      access(0, 0, 0, 0, 0, 0, "R5 prog read n0");
      access(1, 1, 0, 0, 0, 0, "R5 data write n0 back-to-back R9");
      access(2, 0, 1, 6, 0, 0, "R5 io read n1 ready low ignored");
      access(0, 1, 1, 0, 0, 0, "R5 prog write n1");
      // R6: ready handling with two or more waits
      access(0, 1, 2, 0, 0, 0, "R6 n2 ready high");
      access(1, 0, 2, 4, 0, 0, "R6 n2 ready from cycle4");
      access(2, 1, 3, 2, 0, 0, "R6 n3 ready from cycle2");
      access(1, 1, 3, 3, 0, 0, "R6 n3 ready from cycle3");
      // R8: msc looped back to ready
      access(0, 0, 3, 0, 1, 0, "R8 loopback n3");
      access(1, 1, 7, 0, 1, 0, "R8 loopback n7");
      access(2, 0, 2, 0, 1, 0, "R8 loopback n2");
      // R10: request during busy ignored, inputs captured at acceptance
      access(1, 0, 3, 6, 0, 1, "R10 busy request ignored");
      // R7: long software wait run
      access(0, 0, 5, 0, 0, 0, "R7 n5 msc window");

      // R2: reserved space code starts nothing
      req = 1'b1; req_space = 2'b11; wait_cnt = W'(2);
      @(negedge clk);
      req = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk(ps_n && ds_n && is_n && !done, "R2 reserved code ignored",
             {ps_n, ds_n, is_n, done}, 14);
      end
      chk(q.size() == 0, "R9 all accesses completed", q.size(), 0);
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule